// File: doc/BRIEF.md
# Memory Write Protection Controller

This block sits between the command decoder of a serial byte-addressed nonvolatile memory and its storage array. It decides, one byte at a time, whether an incoming write may reach the main array. It also decides whether a write to the status register may proceed. The decision rests on four things: a write-enable latch, a two-bit block-protect field, a protect-enable status bit and an active-low write-protect pin.

The latch is held as a three-state machine. In `ST_IDLE` the latch is clear. In `ST_ARMED` it is set and no array write is in progress. In `ST_BURST` it is set and an array write command is streaming bytes. The transitions are as follows:
- `ST_IDLE` goes to `ST_ARMED` on a write-enable command.
- `ST_ARMED` goes to `ST_BURST` on the first array byte.
- `ST_BURST` stays in `ST_BURST` on further bytes.
- Any set state returns to `ST_IDLE` on a write-disable command, on a status register write command, or on the end of an array write command.

The block also owns the array byte-address counter. The counter is loaded from the address phase and steps after every data byte, so a dropped byte still moves the pointer forward. The permit outputs are combinational in the cycle of the request. Latch and counter changes appear one clock later.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the write-enable latch output `wel` is 0 and `cur_addr` is 0.
- R2: A `cmd_wren` pulse sets `wel` to 1 in the next cycle, unless a `cmd_wrdi`, `sts_wr_req` or `wr_done` pulse is in the same cycle.
- R3: A `cmd_wrdi` pulse clears `wel` in the next cycle. It wins over a `cmd_wren` in the same cycle.
- R4: `sts_wr_en` is 1 exactly when `sts_wr_req` is 1, `wel` is 1, and the pin lock is not active. The pin lock is active when `lock_en` is 1 and `wp_n` is 0.
- R5: When `wp_n` is 1, or `lock_en` is 0, the pin has no effect on `sts_wr_en`.
- R6: A `sts_wr_req` pulse clears `wel` in the next cycle, whether the write was permitted or blocked.
- R7: `arr_wr_en` is 1 exactly when `byte_wr` is 1, `wel` is 1, and `cur_addr` lies outside the protected range. The range is set by `blk_sel`:
  - 00: nothing is protected.
  - 01: the top quarter is protected (addresses 0xC0000 to 0xFFFFF, that is `cur_addr[19:18]`=11).
  - 10: the top half is protected (addresses 0x80000 to 0xFFFFF).
  - 11: the whole array is protected.
- R8: An `addr_load` pulse loads `addr_in[19:0]` into `cur_addr` in the next cycle. The bits `addr_in[23:20]` are ignored.
- R9: Every `byte_wr` pulse advances `cur_addr` by 1 in the next cycle, whether the byte was permitted or dropped. The counter wraps from 0xFFFFF to 0.
- R10: `wel` stays 1 across several bytes of one array write. A `wr_done` pulse clears it in the next cycle.
- R11: `wp_n` and `lock_en` have no effect on `arr_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write-protect pin, active low |
| lock_en | input | 1 | Status bit that enables the pin lock |
| blk_sel | input | 2 | Block-protect field |
| cmd_wren | input | 1 | Write-enable command pulse |
| cmd_wrdi | input | 1 | Write-disable command pulse |
| sts_wr_req | input | 1 | Status register write command pulse |
| addr_load | input | 1 | Load pulse for the address counter |
| addr_in | input | 24 | Address received on the bus |
| byte_wr | input | 1 | An array data byte has arrived |
| wr_done | input | 1 | End of an array write command |
| wel | output | 1 | Write-enable latch state |
| cur_addr | output | 20 | Current array byte address |
| arr_wr_en | output | 1 | Permit for the present array byte |
| sts_wr_en | output | 1 | Permit for the present status write |

## Verification
The assertions assume the command decoder behaves in two ways. First, `addr_load` and `byte_wr` never pulse in the same cycle. Second, each command input is a one-cycle pulse. The directed tasks keep to this by raising one command per cycle, apart from the deliberate write-enable plus write-disable collision and an address load beside a write enable. The tasks always clear the pulses on the following clock. The static inputs `wp_n`, `lock_en` and `blk_sel` are changed only between commands, so each permit is judged against settled controls.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int ADDR_W   = 20;
    localparam int BUS_AW   = 24;
    localparam int BLK_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURST = 2'd2
    } wel_state_t;

    typedef enum logic [1:0] {
        BLK_NONE    = 2'b00,
        BLK_QUARTER = 2'b01,
        BLK_HALF    = 2'b10,
        BLK_ALL     = 2'b11
    } blk_mode_t;

endpackage

// File: rtl/wprot_latch_fsm.sv
module wprot_latch_fsm
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic sts_wr_req,
    input  logic byte_wr,
    input  logic wr_done,
    output logic wel
);

    wel_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wrdi || sts_wr_req || wr_done) state_d = ST_IDLE;
                else if (cmd_wren)                      state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cmd_wrdi || sts_wr_req || wr_done) state_d = ST_IDLE;
                else if (byte_wr)                       state_d = ST_BURST;
            end
            ST_BURST: begin
                if (cmd_wrdi || sts_wr_req || wr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wel = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/wprot_range_dec.sv
module wprot_range_dec #(
    parameter int ADDR_W = 20,
    parameter int BLK_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BLK_W-1:0]  blk_sel,
    output logic              in_range
);
    localparam int TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign upper_half    = addr[TOP];
            assign upper_quarter = addr[TOP] & addr[TOP-1];
        end else begin : g_narrow
            assign upper_half    = addr[0];
            assign upper_quarter = addr[0];
        end
    endgenerate

    always_comb begin
        unique case (blk_sel[1:0])
            2'b00:   in_range = 1'b0;
            2'b01:   in_range = upper_quarter;
            2'b10:   in_range = upper_half;
            default: in_range = 1'b1;
        endcase
    end

endmodule

// File: rtl/wprot_addr_ctr.sv
module wprot_addr_ctr #(
    parameter int ADDR_W = 20,
    parameter int BUS_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [BUS_AW-1:0] addr_in,
    input  logic              byte_wr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cur_addr <= '0;
        else if (addr_load) cur_addr <= addr_in[ADDR_W-1:0];
        else if (byte_wr)   cur_addr <= cur_addr + ONE;
    end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              lock_en,
    input  logic [BLK_W-1:0]  blk_sel,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              sts_wr_req,
    input  logic              addr_load,
    input  logic [BUS_AW-1:0] addr_in,
    input  logic              byte_wr,
    input  logic              wr_done,
    output logic              wel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              arr_wr_en,
    output logic              sts_wr_en
);

    logic in_range;
    logic pin_lock;

    wprot_latch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wren   (cmd_wren),
        .cmd_wrdi   (cmd_wrdi),
        .sts_wr_req (sts_wr_req),
        .byte_wr    (byte_wr),
        .wr_done    (wr_done),
        .wel        (wel)
    );

    wprot_addr_ctr #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .addr_in   (addr_in),
        .byte_wr   (byte_wr),
        .cur_addr  (cur_addr)
    );

    wprot_range_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .addr     (cur_addr),
        .blk_sel  (blk_sel),
        .in_range (in_range)
    );

    always_comb begin
        pin_lock  = lock_en & ~wp_n;
        arr_wr_en = byte_wr & wel & ~in_range;
        sts_wr_en = sts_wr_req & wel & ~pin_lock;
    end

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk
    import wprot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              lock_en,
    input logic [BLK_W-1:0]  blk_sel,
    input logic              cmd_wren,
    input logic              cmd_wrdi,
    input logic              sts_wr_req,
    input logic              addr_load,
    input logic              byte_wr,
    input logic              wr_done,
    input logic              wel,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              arr_wr_en,
    input logic              sts_wr_en
);

    assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !sts_wr_req && !wr_done) |=> wel);

    assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrdi |=> !wel);

    assert_pin_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && !wp_n) |-> !sts_wr_en);

    assert_sts_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_en |-> wel);

    assert_sts_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_req |=> !wel);

    assert_arr_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (wel && byte_wr));

    assert_all_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_sel == 2'b11) |-> !arr_wr_en);

    assert_addr_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !addr_load) |=> (cur_addr == $past(cur_addr) + 1'b1));

    assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wel);

endmodule

bind wprot_ctrl wprot_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .lock_en    (lock_en),
    .blk_sel    (blk_sel),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .sts_wr_req (sts_wr_req),
    .addr_load  (addr_load),
    .byte_wr    (byte_wr),
    .wr_done    (wr_done),
    .wel        (wel),
    .cur_addr   (cur_addr),
    .arr_wr_en  (arr_wr_en),
    .sts_wr_en  (sts_wr_en)
);

// File: tb/wprot_ctrl_bench.sv
`timescale 1ns/1ps
module wprot_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        lock_en = 1'b0;
    logic [1:0]  blk_sel = 2'b00;
    logic        cmd_wren = 1'b0;
    logic        cmd_wrdi = 1'b0;
    logic        sts_wr_req = 1'b0;
    logic        addr_load = 1'b0;
    logic [23:0] addr_in = '0;
    logic        byte_wr = 1'b0;
    logic        wr_done = 1'b0;
    logic        wel;
    logic [19:0] cur_addr;
    logic        arr_wr_en;
    logic        sts_wr_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wprot_ctrl u_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .lock_en(lock_en),
        .blk_sel(blk_sel), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .sts_wr_req(sts_wr_req), .addr_load(addr_load), .addr_in(addr_in),
        .byte_wr(byte_wr), .wr_done(wr_done), .wel(wel), .cur_addr(cur_addr),
        .arr_wr_en(arr_wr_en), .sts_wr_en(sts_wr_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit prot_model(input logic [1:0] b, input logic [19:0] a);
        case (b)
            2'b00:   return 1'b0;
            2'b01:   return a >= 20'hC0000;
            2'b10:   return a >= 20'h80000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; sts_wr_req = 0;
        addr_load = 0; byte_wr = 0; wr_done = 0;
    endtask

    task automatic do_wren();
        cmd_wren = 1; tick();
    endtask

    task automatic do_load(input logic [23:0] a);
        addr_load = 1; addr_in = a; tick();
    endtask

    task automatic t_reset();
        check("R1 wel after reset", wel, 0);
        check("R1 cur_addr after reset", cur_addr, 0);
    endtask

    task automatic t_latch();
        do_wren();
        check("R2 wren sets wel", wel, 1);
        cmd_wrdi = 1; tick();
        check("R3 wrdi clears wel", wel, 0);
        do_wren();
        cmd_wren = 1; cmd_wrdi = 1; tick();
        check("R3 wrdi wins over wren", wel, 0);
    endtask

    task automatic t_status();
        lock_en = 1; wp_n = 0;
        do_wren();
        sts_wr_req = 1; #1;
        check("R4 pin lock blocks status write", sts_wr_en, 0);
        tick();
        check("R6 blocked status write clears wel", wel, 0);
        wp_n = 1;
        do_wren();
        sts_wr_req = 1; #1;
        check("R5 pin high lets status write", sts_wr_en, 1);
        tick();
        check("R6 status write clears wel", wel, 0);
        lock_en = 0; wp_n = 0;
        do_wren();
        sts_wr_req = 1; #1;
        check("R5 lock_en 0 ignores pin", sts_wr_en, 1);
        tick();
        wp_n = 1;
        sts_wr_req = 1; #1;
        check("R4 no latch no status write", sts_wr_en, 0);
        tick();
    endtask

    task automatic t_burst();
        blk_sel = 2'b00;
        do_load(24'hF_FFFFE);
        check("R8 upper bits ignored on load", cur_addr, 20'hFFFFE);
        do_wren();
        byte_wr = 1; #1;
        check("R7 first byte permitted", arr_wr_en, 1);
        tick();
        check("R9 address advanced", cur_addr, 20'hFFFFF);
        check("R10 wel held in burst", wel, 1);
        byte_wr = 1; #1;
        check("R7 second byte permitted", arr_wr_en, 1);
        tick();
        check("R9 address wraps to zero", cur_addr, 0);
        wr_done = 1; tick();
        check("R10 done clears wel", wel, 0);
        byte_wr = 1; #1;
        check("R7 byte without latch dropped", arr_wr_en, 0);
        tick();
        check("R9 dropped byte still advances", cur_addr, 1);
    endtask

    task automatic t_blocks();
        logic [19:0] pts [4] = '{20'h7FFFF, 20'h80000, 20'hBFFFF, 20'hC0000};
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 4; p++) begin
                blk_sel = 2'(b);
                addr_load = 1; addr_in = {4'h0, pts[p]}; cmd_wren = 1; tick();
                byte_wr = 1; #1;
                check($sformatf("R7 blk=%0d addr=%0h", b, pts[p]), arr_wr_en,
                      !prot_model(2'(b), pts[p]));
                tick();
                check("R9 advance after byte", cur_addr, pts[p] + 20'd1);
                wr_done = 1; tick();
            end
        end
        blk_sel = 2'b00; lock_en = 1; wp_n = 0;
        do_load(24'h0_C0000);
        do_wren();
        byte_wr = 1; #1;
        check("R11 pin does not gate array writes", arr_wr_en, 1);
        tick();
        wr_done = 1; tick();
        lock_en = 0; wp_n = 1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_status();
        t_burst();
        t_blocks();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule